// File: doc/BRIEF.md
# Fault Priority Escalation Unit

This block sits beside a processor core and decides how each synchronous fault is taken. Three configurable fault classes can be raised: memory-management (class 0), bus (class 1) and usage (class 2). Each class has a software-programmed priority and a handler enable bit. When a fault strobe arrives, the unit compares the fault against the core's current execution context. It then either dispatches the fault's own handler or redirects the fault to the hard fault handler. Hard fault has a fixed priority that ranks above every configurable level. A smaller priority number means higher urgency.

Redirection to hard fault happens in four cases: the class handler is disabled, the fault cannot preempt the running context, a handler faults while it is running, or the hard fault handler itself is running. There is one exemption. A bus fault flagged as raised by the stack push on entry to the bus fault handler is always given to the bus fault handler. A fault that would escalate while the hard fault handler is running puts the unit into a sticky lockup state, and lockup raises a system reset request.

The unit also keeps sticky cause bits that software clears by writing one, and a bus fault address register with its own valid flag. A small word-wide register port gives access to priorities, enables, status and address. Instruction execution, stacking and vector fetch are outside the block and appear only as input strobes and context inputs.

Top module: `fault_escalation_unit`

## Requirements
- R1: While reset is high and in the cycle after it, dispatch strobe, escalated flag, lockup and reset request are low, and every register reads 0: priorities, enables (all handlers disabled), both status words and the address.
- R2: A fault strobed in cycle t gives a single-cycle `dsp_vld` in cycle t+1. The handler id is the class number (0 memory, 1 bus, 2 usage) with `dsp_esc` low when three conditions hold: the class is enabled, the hard handler is not running, and either `cur_active` is low or the class priority is numerically below `cur_prio`.
- R3: A fault whose class handler is disabled is dispatched with handler id 3 (hard fault) and `dsp_esc` high. A dispatch with id 3 always has `dsp_esc` high, and `dsp_esc` is never high without a dispatch.
- R4: With `cur_active` high, a fault whose priority is equal to or numerically above `cur_prio` escalates to handler id 3. This includes a handler faulting at its own level.
- R5: A fault that would escalate while `cur_hard` is high produces no dispatch. Instead `lockup` and `sys_rst_req` go high in the next cycle and stay high until reset, and no fault is dispatched during lockup.
- R6: A bus fault that wins arbitration with `flt_stack` high is dispatched to the bus handler (id 1) with `dsp_esc` low, whatever the bus enable, the priorities or `cur_hard`.
- R7: When several faults are strobed together, the smallest priority value wins and ties go to the lower class number. Only the winner is dispatched and recorded in status.
- R8: Status word (address 2) bits: bit 0 memory fault, bit 1 bus data fault, bit 2 bus stacking fault, bit 3 address valid, bit 4 usage fault. Hard status (address 3) bit 0 is set whenever a fault escalates, including one that causes lockup.
- R9: Writing to addresses 2 and 3 clears each bit written as one and leaves bits written as zero untouched. A set and a clear of the same bit in the same cycle leave the bit set.
- R10: A winning non-stacking bus fault loads `flt_addr` into the address register (address 4) and sets the valid bit, but only when the valid bit was clear before that cycle. Otherwise the address holds, and clearing the valid bit leaves the address unchanged.
- R11: Address 0 holds the memory, bus and usage priorities in bits [7:0], [15:8] and [23:16] (low PRIO_W bits used). Address 1 holds the enables in bits 0 to 2. `reg_rdata` shows the word selected by `reg_addr` one cycle later, and unmapped addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flt_vld | input | 3 | Fault strobes, bit n for class n |
| flt_stack | input | 1 | Bus fault came from handler-entry stacking |
| flt_addr | input | ADDR_W | Address of the faulting bus access |
| cur_active | input | 1 | A handler context is running |
| cur_prio | input | PRIO_W | Priority of the running context |
| cur_hard | input | 1 | The hard fault handler is running |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| dsp_vld | output | 1 | Dispatch strobe |
| dsp_hid | output | 2 | Handler id: 0 memory, 1 bus, 2 usage, 3 hard |
| dsp_esc | output | 1 | Dispatch was escalated to hard fault |
| lockup | output | 1 | Sticky lockup state |
| sys_rst_req | output | 1 | System reset request |

## Verification
The bench builds the unit with PRIO_W = 2 and ADDR_W = 12. Four priority levels make equal priorities easy to set up, so ties between classes and faults at the running level can be reached with a few register writes. The narrow address keeps the capture and hold values readable while still showing that the full address field moves. A behavioural model runs next to the design on every clock, and directed scenarios walk through disabled handlers, recursion, stacking exemption under the hard handler and lockup.

// File: rtl/fault_pkg.sv
package fault_pkg;
  localparam int NUM_CFG   = 3;
  localparam int CLS_MEM   = 0;
  localparam int CLS_BUS   = 1;
  localparam int CLS_USE   = 2;
  localparam int PRIO_LANE = 8;
  localparam int RA_W      = 3;
  localparam int CFS_W     = 5;
  localparam int B_MEM     = 0;
  localparam int B_BUS     = 1;
  localparam int B_STK     = 2;
  localparam int B_AV      = 3;
  localparam int B_USE     = 4;

  localparam logic [RA_W-1:0] RA_PRIO = 3'd0;
  localparam logic [RA_W-1:0] RA_EN   = 3'd1;
  localparam logic [RA_W-1:0] RA_CFS  = 3'd2;
  localparam logic [RA_W-1:0] RA_HFS  = 3'd3;
  localparam logic [RA_W-1:0] RA_ADDR = 3'd4;

  typedef enum logic [1:0] {
    HID_MEM  = 2'd0,
    HID_BUS  = 2'd1,
    HID_USE  = 2'd2,
    HID_HARD = 2'd3
  } hid_e;
endpackage

// File: rtl/fault_arbiter.sv
module fault_arbiter #(
  parameter int N      = 3,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]             req,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     any,
  output logic [IDX_W-1:0]         win,
  output logic [PRIO_W-1:0]        win_prio
);
  // Linear chain: a later class only wins with a strictly smaller value,
  // so equal priorities resolve to the lower class number.
  logic              fnd [N+1];
  logic [PRIO_W-1:0] bp  [N+1];
  logic [IDX_W-1:0]  bi  [N+1];

  assign fnd[0] = 1'b0;
  assign bp[0]  = '0;
  assign bi[0]  = '0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    logic take;
    assign take     = req[i] && (!fnd[i] || (prio[i] < bp[i]));
    assign fnd[i+1] = fnd[i] | req[i];
    assign bp[i+1]  = take ? prio[i] : bp[i];
    assign bi[i+1]  = take ? IDX_W'(i) : bi[i];
  end

  assign any      = fnd[N];
  assign win      = bi[N];
  assign win_prio = bp[N];
endmodule

// File: rtl/fault_decide.sv
module fault_decide import fault_pkg::*; #(
  parameter int N      = 3,
  parameter int PRIO_W = 3,
  localparam int IDX_W = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              any,
  input  logic [IDX_W-1:0]  win,
  input  logic [PRIO_W-1:0] win_prio,
  input  logic [N-1:0]      hen,
  input  logic              flt_stack,
  input  logic              cur_active,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              cur_hard,
  output logic              rec,
  output logic              esc_c,
  output logic              exempt,
  output logic              dsp_vld,
  output hid_e              dsp_hid,
  output logic              dsp_esc,
  output logic              lockup
);
  logic no_preempt, lock_c;

  assign rec        = any && !lockup;
  assign exempt     = flt_stack && (win == IDX_W'(CLS_BUS));
  assign no_preempt = cur_active && (win_prio >= cur_prio);
  assign esc_c      = !exempt && (!hen[win] || no_preempt || cur_hard);
  assign lock_c     = esc_c && cur_hard;

  always_ff @(posedge clk) begin
    if (rst) begin
      dsp_vld <= 1'b0;
      dsp_hid <= HID_MEM;
      dsp_esc <= 1'b0;
      lockup  <= 1'b0;
    end else begin
      dsp_vld <= rec && !lock_c;
      dsp_esc <= rec && esc_c && !lock_c;
      dsp_hid <= !(rec && !lock_c) ? HID_MEM :
                 esc_c             ? HID_HARD : hid_e'(2'(win));
      lockup  <= lockup | (rec && lock_c);
    end
  end
endmodule

// File: rtl/fault_cfg_regs.sv
module fault_cfg_regs import fault_pkg::*; #(
  parameter int N      = 3,
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     reg_wr,
  input  logic [RA_W-1:0]          reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [31:0]              reg_rdata,
  input  logic [CFS_W-1:0]         cfs_set,
  input  logic                     hfs_set,
  input  logic [ADDR_W-1:0]        cap_addr,
  output logic [N-1:0][PRIO_W-1:0] prio,
  output logic [N-1:0]             hen,
  output logic [ADDR_W-1:0]        bfa,
  output logic                     bfa_vld
);
  logic [CFS_W-1:0] cfs_q, cfs_clr, cfs_in;
  logic             hfs_q, hfs_clr, cap;
  logic [31:0]      rd_c;

  // Address is taken only while the valid flag was clear before this cycle.
  assign cap     = cfs_set[B_AV] && !cfs_q[B_AV];
  assign cfs_clr = (reg_wr && reg_addr == RA_CFS) ? reg_wdata[CFS_W-1:0] : '0;
  assign hfs_clr = reg_wr && reg_addr == RA_HFS && reg_wdata[0];
  always_comb begin
    cfs_in       = cfs_set;
    cfs_in[B_AV] = cap;
  end
  assign bfa_vld = cfs_q[B_AV];

  always_ff @(posedge clk) begin
    if (rst) begin
      prio  <= '0;
      hen   <= '0;
      cfs_q <= '0;
      hfs_q <= 1'b0;
      bfa   <= '0;
    end else begin
      if (reg_wr && reg_addr == RA_PRIO)
        for (int i = 0; i < N; i++) prio[i] <= reg_wdata[i*PRIO_LANE +: PRIO_W];
      if (reg_wr && reg_addr == RA_EN) hen <= reg_wdata[N-1:0];
      cfs_q <= (cfs_q & ~cfs_clr) | cfs_in;
      hfs_q <= (hfs_q & ~hfs_clr) | hfs_set;
      if (cap) bfa <= cap_addr;
    end
  end

  always_comb begin
    rd_c = '0;
    case (reg_addr)
      RA_PRIO: for (int i = 0; i < N; i++) rd_c[i*PRIO_LANE +: PRIO_W] = prio[i];
      RA_EN:   rd_c[N-1:0]     = hen;
      RA_CFS:  rd_c[CFS_W-1:0] = cfs_q;
      RA_HFS:  rd_c[0]         = hfs_q;
      RA_ADDR: rd_c            = 32'(bfa);
      default: rd_c            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_c;
  end
endmodule

// File: rtl/fault_escalation_unit.sv
module fault_escalation_unit import fault_pkg::*; #(
  parameter int PRIO_W = 3,
  parameter int ADDR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [2:0]         flt_vld,
  input  logic               flt_stack,
  input  logic [ADDR_W-1:0]  flt_addr,
  input  logic               cur_active,
  input  logic [PRIO_W-1:0]  cur_prio,
  input  logic               cur_hard,
  input  logic               reg_wr,
  input  logic [2:0]         reg_addr,
  input  logic [31:0]        reg_wdata,
  output logic [31:0]        reg_rdata,
  output logic               dsp_vld,
  output logic [1:0]         dsp_hid,
  output logic               dsp_esc,
  output logic               lockup,
  output logic               sys_rst_req
);
  localparam int IDX_W = $clog2(NUM_CFG);

  logic [NUM_CFG-1:0][PRIO_W-1:0] prio;
  logic [NUM_CFG-1:0]             hen;
  logic                           any, rec, esc_c, exempt;
  logic [IDX_W-1:0]               win;
  logic [PRIO_W-1:0]              win_prio;
  logic [CFS_W-1:0]               cfs_set;
  logic [ADDR_W-1:0]              bfa;
  logic                           bfa_vld;
  hid_e                           hid_q;

  fault_arbiter #(.N(NUM_CFG), .PRIO_W(PRIO_W)) u_arb (
    .req(flt_vld), .prio(prio), .any(any), .win(win), .win_prio(win_prio)
  );

  fault_decide #(.N(NUM_CFG), .PRIO_W(PRIO_W)) u_dec (
    .clk(clk), .rst(rst), .any(any), .win(win), .win_prio(win_prio),
    .hen(hen), .flt_stack(flt_stack), .cur_active(cur_active),
    .cur_prio(cur_prio), .cur_hard(cur_hard), .rec(rec), .esc_c(esc_c),
    .exempt(exempt), .dsp_vld(dsp_vld), .dsp_hid(hid_q), .dsp_esc(dsp_esc),
    .lockup(lockup)
  );

  // Cause bits for the winning class only.
  always_comb begin
    cfs_set = '0;
    if (rec) begin
      case (win)
        IDX_W'(CLS_MEM): cfs_set[B_MEM] = 1'b1;
        IDX_W'(CLS_BUS): begin
          if (exempt) cfs_set[B_STK] = 1'b1;
          else begin
            cfs_set[B_BUS] = 1'b1;
            cfs_set[B_AV]  = 1'b1;
          end
        end
        IDX_W'(CLS_USE): cfs_set[B_USE] = 1'b1;
        default: cfs_set = '0;
      endcase
    end
  end

  fault_cfg_regs #(.N(NUM_CFG), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfs_set(cfs_set),
    .hfs_set(rec && esc_c), .cap_addr(flt_addr), .prio(prio), .hen(hen),
    .bfa(bfa), .bfa_vld(bfa_vld)
  );

  assign dsp_hid     = hid_q;
  assign sys_rst_req = lockup;
endmodule

// File: rtl/fault_escalation_chk.sv
module fault_escalation_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [2:0]        flt_vld,
  input logic              flt_stack,
  input logic              dsp_vld,
  input logic [1:0]        dsp_hid,
  input logic              dsp_esc,
  input logic              lockup,
  input logic [ADDR_W-1:0] bfa,
  input logic              bfa_vld
);
  assert_dispatch_follows_fault_R2: assert property (@(posedge clk) disable iff (rst)
    dsp_vld |-> $past(|flt_vld));

  assert_hard_is_escalated_R3: assert property (@(posedge clk) disable iff (rst)
    (dsp_vld && dsp_hid == 2'd3) |-> dsp_esc);

  assert_esc_needs_dispatch_R3: assert property (@(posedge clk) disable iff (rst)
    dsp_esc |-> (dsp_vld && dsp_hid == 2'd3));

  assert_lockup_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    lockup |=> lockup);

  assert_no_dispatch_locked_R5: assert property (@(posedge clk) disable iff (rst)
    lockup |-> !dsp_vld);

  assert_stack_exempt_R6: assert property (@(posedge clk) disable iff (rst)
    $past(flt_vld == 3'b010 && flt_stack && !lockup) |->
      (dsp_vld && dsp_hid == 2'd1 && !dsp_esc));

  assert_addr_held_R10: assert property (@(posedge clk) disable iff (rst)
    ($past(bfa_vld) && bfa_vld) |-> $stable(bfa));
endmodule

bind fault_escalation_unit fault_escalation_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .flt_vld(flt_vld), .flt_stack(flt_stack),
  .dsp_vld(dsp_vld), .dsp_hid(dsp_hid), .dsp_esc(dsp_esc), .lockup(lockup),
  .bfa(bfa), .bfa_vld(bfa_vld)
);

// File: tb/sim_fault_escalation_unit.sv
`timescale 1ns/1ps
module sim_fault_escalation_unit;
  localparam int PW = 2;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [2:0]    flt_vld = '0;
  logic          flt_stack = 1'b0;
  logic [AW-1:0] flt_addr = '0;
  logic          cur_active = 1'b0;
  logic [PW-1:0] cur_prio = '0;
  logic          cur_hard = 1'b0;
  logic          reg_wr = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          dsp_vld, dsp_esc, lockup, sys_rst_req;
  logic [1:0]    dsp_hid;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  fault_escalation_unit #(.PRIO_W(PW), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .flt_vld(flt_vld), .flt_stack(flt_stack),
    .flt_addr(flt_addr), .cur_active(cur_active), .cur_prio(cur_prio),
    .cur_hard(cur_hard), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dsp_vld(dsp_vld),
    .dsp_hid(dsp_hid), .dsp_esc(dsp_esc), .lockup(lockup),
    .sys_rst_req(sys_rst_req)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int       m_prio [3];
  int       m_en, m_cfs, m_hfs, m_addr;
  bit       m_lock, started;
  int       e_vld, e_hid, e_esc, e_rd;
  int       w, cset, cclr, hclr;
  bit       esc, exm, hset;

  function automatic int rd_model(input int a);
    case (a)
      0: return (m_prio[2] << 16) | (m_prio[1] << 8) | m_prio[0];
      1: return m_en;
      2: return m_cfs;
      3: return m_hfs;
      4: return m_addr;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_prio = '{0, 0, 0};
      m_en = 0; m_cfs = 0; m_hfs = 0; m_addr = 0; m_lock = 0;
      e_vld = 0; e_hid = 0; e_esc = 0; e_rd = 0;
      started = 1;
    end else begin
      e_rd = rd_model(int'(reg_addr));
      w = -1;
      if (!m_lock)
        for (int i = 0; i < 3; i++)
          if (flt_vld[i] && (w < 0 || m_prio[i] < m_prio[w])) w = i;
      e_vld = 0; e_hid = 0; e_esc = 0; cset = 0; hset = 0;
      if (w >= 0) begin
        exm = flt_stack && (w == 1);
        esc = !exm && (((m_en >> w) & 1) == 0 ||
                       (cur_active && m_prio[w] >= int'(cur_prio)) || cur_hard);
        hset = esc;
        if (esc && cur_hard) m_lock = 1;
        else begin
          e_vld = 1; e_esc = esc; e_hid = esc ? 3 : w;
        end
        if (w == 0) cset = 1;
        else if (w == 2) cset = 16;
        else if (exm) cset = 4;
        else begin
          cset = 2;
          if ((m_cfs & 8) == 0) begin cset = cset | 8; m_addr = int'(flt_addr); end
        end
      end
      cclr = 0; hclr = 0;
      if (reg_wr) begin
        case (reg_addr)
          3'd0: for (int i = 0; i < 3; i++) m_prio[i] = (reg_wdata >> (8*i)) & ((1 << PW) - 1);
          3'd1: m_en = reg_wdata & 7;
          3'd2: cclr = reg_wdata & 31;
          3'd3: hclr = reg_wdata & 1;
          default: ;
        endcase
      end
      m_cfs = (m_cfs & ~cclr) | cset;
      m_hfs = (m_hfs & ~hclr) | int'(hset);
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (started && !done) begin
      chk(int'(dsp_vld) == e_vld, "R2 model dispatch strobe", int'(dsp_vld), e_vld);
      if (e_vld != 0) begin
        chk(int'(dsp_hid) == e_hid, "R2 model handler id", int'(dsp_hid), e_hid);
        chk(int'(dsp_esc) == e_esc, "R3 model escalated flag", int'(dsp_esc), e_esc);
      end
      chk(lockup == m_lock, "R5 model lockup", int'(lockup), int'(m_lock));
      chk(sys_rst_req == m_lock, "R5 model reset request", int'(sys_rst_req), int'(m_lock));
      chk(int'(reg_rdata) == e_rd, "R11 model read data", int'(reg_rdata), e_rd);
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk); reg_addr = a;
    @(negedge clk); chk(int'(reg_rdata) == exp, tag, int'(reg_rdata), exp);
  endtask

  task automatic flt(input logic [2:0] v, input bit stk, input int addr,
                     input int ev, input int eh, input int ee, input string tag);
    @(negedge clk); flt_vld = v; flt_stack = stk; flt_addr = AW'(addr);
    @(negedge clk);
    chk(int'(dsp_vld) == ev, tag, int'(dsp_vld), ev);
    if (ev != 0) begin
      chk(int'(dsp_hid) == eh, tag, int'(dsp_hid), eh);
      chk(int'(dsp_esc) == ee, tag, int'(dsp_esc), ee);
    end
    flt_vld = '0; flt_stack = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(dsp_vld == 0 && lockup == 0 && sys_rst_req == 0, "R1 outputs after reset",
        int'({dsp_vld, lockup, sys_rst_req}), 0);
    for (int a = 0; a < 5; a++) rd(3'(a), 0, "R1 register reset value");

    // R3: handlers disabled after reset
    flt(3'b001, 0, 0, 1, 3, 1, "R3 disabled handler escalates");
    rd(3'd3, 1, "R8 hard status escalated bit");
    rd(3'd2, 32'h01, "R8 memory fault bit");

    // R11: configuration
    wr(3'd0, 32'h0003_0102);
    wr(3'd1, 32'h7);
    rd(3'd0, 32'h0003_0102, "R11 priority lanes");
    rd(3'd1, 7, "R11 enable bits");
    rd(3'd7, 0, "R11 unmapped address reads zero");

    flt(3'b100, 0, 0, 1, 2, 0, "R2 usage handler dispatched");
    cur_active = 1'b1; cur_prio = 2'd2;
    flt(3'b010, 0, 'h0AA, 1, 1, 0, "R2 higher priority preempts");
    flt(3'b001, 0, 0, 1, 3, 1, "R4 equal priority escalates");
    flt(3'b100, 0, 0, 1, 3, 1, "R4 lower priority escalates");

    wr(3'd2, 32'h1F);
    wr(3'd3, 32'h1);
    rd(3'd2, 0, "R9 status cleared by writing one");
    rd(3'd3, 0, "R9 hard status cleared");
    rd(3'd4, 'h0AA, "R10 address kept after valid cleared");

    cur_active = 1'b0;
    flt(3'b111, 0, 'h111, 1, 1, 0, "R7 smallest priority wins");
    rd(3'd2, 32'h0A, "R7 only winner recorded");
    wr(3'd0, 32'h0003_0101);
    flt(3'b011, 0, 'h7FF, 1, 0, 0, "R7 tie goes to lower class");

    flt(3'b010, 0, 'h222, 1, 1, 0, "R2 bus dispatch");
    rd(3'd4, 'h111, "R10 address held while valid");
    wr(3'd2, 32'h0);
    rd(3'd2, 32'h0B, "R9 writing zero has no effect");
    wr(3'd2, 32'h08);
    rd(3'd2, 32'h03, "R10 valid flag cleared");
    rd(3'd4, 'h111, "R10 clearing valid keeps address");
    flt(3'b010, 0, 'h333, 1, 1, 0, "R2 bus dispatch");
    rd(3'd4, 'h333, "R10 new capture after clear");
    rd(3'd2, 32'h0B, "R8 valid set again");

    wr(3'd2, 32'h1F);
    @(negedge clk); reg_wr = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1; flt_vld = 3'b001;
    @(negedge clk); reg_wr = 1'b0; flt_vld = '0;
    rd(3'd2, 32'h01, "R9 set wins over clear");

    wr(3'd1, 32'h5);
    flt(3'b010, 1, 'h444, 1, 1, 0, "R6 stacking bus fault not escalated");
    rd(3'd2, 32'h05, "R8 stacking bit");
    rd(3'd4, 'h333, "R10 stacking fault does not capture");

    cur_hard = 1'b1;
    flt(3'b010, 1, 0, 1, 1, 0, "R6 exemption under hard handler");
    chk(lockup == 0, "R6 no lockup from exempt fault", int'(lockup), 0);
    flt(3'b100, 0, 0, 0, 0, 0, "R5 no dispatch at lockup");
    chk(lockup == 1 && sys_rst_req == 1, "R5 lockup and reset request",
        int'({lockup, sys_rst_req}), 3);
    cur_hard = 1'b0;
    flt(3'b001, 0, 0, 0, 0, 0, "R5 faults ignored in lockup");
    chk(lockup == 1, "R5 lockup sticky", int'(lockup), 1);

    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    chk(lockup == 0 && sys_rst_req == 0, "R1 reset leaves lockup",
        int'({lockup, sys_rst_req}), 0);
    rd(3'd0, 0, "R1 priorities reset");

    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
    end
  end
endmodule